// File: doc/BRIEF.md
# Lockstep Element Array with Masked Conditional Execution

This block is a small grid of processing elements that all run in lockstep. Every cycle, a control unit outside the block may present one instruction, and every element acts on it in the same cycle. Each element has a private register file, an activity mask bit and a one-deep saved copy of that mask. An element whose mask bit is set treats every data-writing instruction as a no-op.

Conditional code works without branching. A set-mask instruction evaluates a per-element condition and masks the elements where it fails. The THEN instructions then run on the elements that remain active. An invert instruction flips the mask of the elements that were active before the conditional, so the ELSE instructions run on the complementary subset. A restore instruction brings back the mask as it was before the conditional.

A shift instruction moves a value from each element to a grid neighbour, with all elements moving at once. For observation only, the block drives out one selected register of every element and all mask bits.

Top module: `simd_array`

## Requirements
- R1: After reset, every register of every element and every mask bit and saved mask bit is zero.
- R2: An element with mask bit 1 leaves its registers unchanged on every data-writing instruction (ADD, CMPLT, LDIDX, LDIMM, SHIFT). Elements with mask bit 0 commit the result in the same cycle.
- R3: With instr_op 1 (ADD), rd takes (ra + rb) mod 2^DW. With instr_op 2 (CMPLT), rd takes 1 if ra < rb unsigned and 0 otherwise.
- R4: With instr_op 3 (SETMASK), every element copies its mask into its saved bit. An element whose mask is 0 and where ra < rb (unsigned) is false then sets its mask to 1. An element that was already masked stays masked.
- R5: With instr_op 4 (INVERT), elements whose saved bit is 0 flip their mask bit. Elements whose saved bit is 1 keep their mask bit at 1.
- R6: With instr_op 5 (RESTORE), every element's mask bit takes the value of its saved bit.
- R7: With instr_op 7 (LDIDX), rd takes the element index row*COLS+col. With instr_op 8 (LDIMM), rd takes instr_imm.
- R8: With instr_op 6 (SHIFT), rd takes register ra of the neighbour that instr_dir names: 0 is row-1, 1 is row+1, 2 is col+1, 3 is col-1. When that neighbour lies off the grid, rd receives zero if instr_wrap is 0, or the element at the opposite edge if instr_wrap is 1.
- R9: Opcodes 0 and 9 to 15 change neither registers nor masks.
- R10: When instr_valid is 0, no register or mask changes, whatever the opcode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| instr_valid | input | 1 | The broadcast instruction is present |
| instr_op | input | 4 | Opcode |
| instr_rd | input | $clog2(NREG) | Destination register |
| instr_ra | input | $clog2(NREG) | First source register, also the shift source |
| instr_rb | input | $clog2(NREG) | Second source register |
| instr_imm | input | DW | Immediate for LDIMM |
| instr_dir | input | 2 | Direction of the shift |
| instr_wrap | input | 1 | Wraparound at the grid edges during a shift |
| obs_sel | input | $clog2(NREG) | Register shown on obs_data |
| obs_data | output | ROWS*COLS*DW | Selected register of each element, element i at bits i*DW upward |
| mask_out | output | ROWS*COLS | Mask bit of each element |

## Verification
Every instruction commits at the rising edge where instr_valid is sampled high. Its register and mask effects therefore show on obs_data and mask_out one edge after they are driven, and no result comes later than that. The bench drives each instruction at a falling edge and advances its reference model by one step. At the next falling edge it steps obs_sel through every register and compares all elements and all masks against the model. Instructions are spaced with idle cycles, so each comparison belongs to exactly one instruction.

// File: rtl/simd_pkg.sv
package simd_pkg;
    localparam logic [3:0] OP_NOP     = 4'd0;
    localparam logic [3:0] OP_ADD     = 4'd1;
    localparam logic [3:0] OP_CMPLT   = 4'd2;
    localparam logic [3:0] OP_SETMASK = 4'd3;
    localparam logic [3:0] OP_INVERT  = 4'd4;
    localparam logic [3:0] OP_RESTORE = 4'd5;
    localparam logic [3:0] OP_SHIFT   = 4'd6;
    localparam logic [3:0] OP_LDIDX   = 4'd7;
    localparam logic [3:0] OP_LDIMM   = 4'd8;

    typedef enum logic [1:0] {
        DIR_UP    = 2'd0,
        DIR_DOWN  = 2'd1,
        DIR_RIGHT = 2'd2,
        DIR_LEFT  = 2'd3
    } dir_t;

    function automatic logic op_writes_data(input logic [3:0] op);
        return (op == OP_ADD) || (op == OP_CMPLT) || (op == OP_SHIFT) ||
               (op == OP_LDIDX) || (op == OP_LDIMM);
    endfunction

    function automatic logic op_defined(input logic [3:0] op);
        return (op >= OP_ADD) && (op <= OP_LDIMM);
    endfunction
endpackage

// File: rtl/simd_route.sv
module simd_route #(
    parameter int ROWS = 4,
    parameter int COLS = 4,
    parameter int DW   = 8
) (
    input  logic [ROWS*COLS-1:0][DW-1:0] src_i,
    input  logic [1:0]                   dir_i,
    input  logic                         wrap_i,
    output logic [ROWS*COLS-1:0][DW-1:0] nbr_o
);
    for (genvar r = 0; r < ROWS; r++) begin : g_row
        for (genvar c = 0; c < COLS; c++) begin : g_col
            localparam int ME    = r * COLS + c;
            localparam int UP    = ((r + ROWS - 1) % ROWS) * COLS + c;
            localparam int DOWN  = ((r + 1) % ROWS) * COLS + c;
            localparam int RIGHT = r * COLS + ((c + 1) % COLS);
            localparam int LEFT  = r * COLS + ((c + COLS - 1) % COLS);
            localparam logic EDGE_UP    = (r == 0);
            localparam logic EDGE_DOWN  = (r == ROWS - 1);
            localparam logic EDGE_RIGHT = (c == COLS - 1);
            localparam logic EDGE_LEFT  = (c == 0);

            always_comb begin
                logic       at_edge;
                logic [DW-1:0] pick;
                unique case (dir_i)
                    2'd0:    begin pick = src_i[UP];    at_edge = EDGE_UP;    end
                    2'd1:    begin pick = src_i[DOWN];  at_edge = EDGE_DOWN;  end
                    2'd2:    begin pick = src_i[RIGHT]; at_edge = EDGE_RIGHT; end
                    default: begin pick = src_i[LEFT];  at_edge = EDGE_LEFT;  end
                endcase
                nbr_o[ME] = (at_edge && !wrap_i) ? '0 : pick;
            end
        end
    end
endmodule

// File: rtl/simd_pe.sv
module simd_pe
    import simd_pkg::*;
#(
    parameter int DW   = 8,
    parameter int NREG = 4,
    parameter int IDX  = 0
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    en_i,
    input  logic [3:0]              op_i,
    input  logic [$clog2(NREG)-1:0] rd_i,
    input  logic [$clog2(NREG)-1:0] ra_i,
    input  logic [$clog2(NREG)-1:0] rb_i,
    input  logic [DW-1:0]           imm_i,
    input  logic [DW-1:0]           nbr_i,
    input  logic [$clog2(NREG)-1:0] obs_sel_i,
    output logic [DW-1:0]           src_o,
    output logic [DW-1:0]           obs_o,
    output logic                    mask_o
);
    typedef struct packed {
        logic [NREG-1:0][DW-1:0] regs;
        logic                    mask;
        logic                    saved;
    } pe_state_t;

    pe_state_t st_d, st_q;
    logic [DW-1:0] opa, opb;

    assign opa = st_q.regs[ra_i];
    assign opb = st_q.regs[rb_i];

    always_comb begin
        st_d = st_q;
        if (en_i) begin
            case (op_i)
                OP_ADD:     if (!st_q.mask) st_d.regs[rd_i] = opa + opb;
                OP_CMPLT:   if (!st_q.mask) st_d.regs[rd_i] = (opa < opb) ? DW'(1) : '0;
                OP_LDIDX:   if (!st_q.mask) st_d.regs[rd_i] = DW'(IDX);
                OP_LDIMM:   if (!st_q.mask) st_d.regs[rd_i] = imm_i;
                OP_SHIFT:   if (!st_q.mask) st_d.regs[rd_i] = nbr_i;
                OP_SETMASK: begin
                    st_d.saved = st_q.mask;
                    if (!st_q.mask && !(opa < opb)) st_d.mask = 1'b1;
                end
                OP_INVERT:  if (!st_q.saved) st_d.mask = !st_q.mask;
                OP_RESTORE: st_d.mask = st_q.saved;
                default:    ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign src_o  = st_q.regs[ra_i];
    assign obs_o  = st_q.regs[obs_sel_i];
    assign mask_o = st_q.mask;

    p_masked_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (en_i && st_q.mask && op_writes_data(op_i)) |=> $stable(st_q.regs));

    p_sticky_mask_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (en_i && op_i == OP_SETMASK && st_q.mask) |=> (st_q.mask && st_q.saved));

    p_invert_keeps_outer_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (en_i && op_i == OP_INVERT && st_q.saved) |=> st_q.mask == $past(st_q.mask));

    p_restore_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (en_i && op_i == OP_RESTORE) |=> st_q.mask == $past(st_q.saved));

    p_undefined_nop_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (en_i && !op_defined(op_i)) |=> $stable(st_q));

    p_idle_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!en_i) |=> $stable(st_q));
endmodule

// File: rtl/simd_array.sv
module simd_array #(
    parameter int ROWS = 4,
    parameter int COLS = 4,
    parameter int DW   = 8,
    parameter int NREG = 4
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    instr_valid,
    input  logic [3:0]              instr_op,
    input  logic [$clog2(NREG)-1:0] instr_rd,
    input  logic [$clog2(NREG)-1:0] instr_ra,
    input  logic [$clog2(NREG)-1:0] instr_rb,
    input  logic [DW-1:0]           instr_imm,
    input  logic [1:0]              instr_dir,
    input  logic                    instr_wrap,
    input  logic [$clog2(NREG)-1:0] obs_sel,
    output logic [ROWS*COLS*DW-1:0] obs_data,
    output logic [ROWS*COLS-1:0]    mask_out
);
    localparam int NPE = ROWS * COLS;

    logic [NPE-1:0][DW-1:0] src;
    logic [NPE-1:0][DW-1:0] nbr;

    simd_route #(.ROWS(ROWS), .COLS(COLS), .DW(DW)) u_route (
        .src_i  (src),
        .dir_i  (instr_dir),
        .wrap_i (instr_wrap),
        .nbr_o  (nbr)
    );

    for (genvar i = 0; i < NPE; i++) begin : g_pe
        simd_pe #(.DW(DW), .NREG(NREG), .IDX(i)) u_pe (
            .clk       (clk),
            .rst_n     (rst_n),
            .en_i      (instr_valid),
            .op_i      (instr_op),
            .rd_i      (instr_rd),
            .ra_i      (instr_ra),
            .rb_i      (instr_rb),
            .imm_i     (instr_imm),
            .nbr_i     (nbr[i]),
            .obs_sel_i (obs_sel),
            .src_o     (src[i]),
            .obs_o     (obs_data[i*DW +: DW]),
            .mask_o    (mask_out[i])
        );
    end
endmodule

// File: tb/sim_simd_array.sv
module sim_simd_array;
    localparam int ROWS = 4;
    localparam int COLS = 4;
    localparam int DW   = 8;
    localparam int NREG = 4;
    localparam int NPE  = ROWS * COLS;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic instr_valid = 1'b0;
    logic [3:0] instr_op = '0;
    logic [1:0] instr_rd = '0, instr_ra = '0, instr_rb = '0, obs_sel = '0;
    logic [DW-1:0] instr_imm = '0;
    logic [1:0] instr_dir = '0;
    logic instr_wrap = 1'b0;
    logic [NPE*DW-1:0] obs_data;
    logic [NPE-1:0] mask_out;

    always #5 clk = ~clk;

    simd_array #(.ROWS(ROWS), .COLS(COLS), .DW(DW), .NREG(NREG)) u0 (
        .clk(clk), .rst_n(rst_n), .instr_valid(instr_valid), .instr_op(instr_op),
        .instr_rd(instr_rd), .instr_ra(instr_ra), .instr_rb(instr_rb),
        .instr_imm(instr_imm), .instr_dir(instr_dir), .instr_wrap(instr_wrap),
        .obs_sel(obs_sel), .obs_data(obs_data), .mask_out(mask_out)
    );

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 0;

    int m_reg  [NPE][NREG];
    bit m_mask [NPE];
    bit m_saved[NPE];

    function automatic int neighbour(int i, int dir, bit wrap);
        int r, c;
        r = i / COLS;
        c = i % COLS;
        case (dir)
            0: r = r - 1;
            1: r = r + 1;
            2: c = c + 1;
            default: c = c - 1;
        endcase
        if (r < 0 || r >= ROWS || c < 0 || c >= COLS) begin
            if (!wrap) return -1;
            r = (r + ROWS) % ROWS;
            c = (c + COLS) % COLS;
        end
        return r * COLS + c;
    endfunction

    task automatic compare_all(string tag);
        bit bad;
        for (int s = 0; s < NREG; s++) begin
            obs_sel = 2'(s);
            #1;
            bad = 0;
            for (int i = 0; i < NPE; i++) begin
                if (!bad && obs_data[i*DW +: DW] !== DW'(m_reg[i][s])) begin
                    $display("FAIL %s: element %0d reg %0d actual %0d expected %0d",
                             tag, i, s, obs_data[i*DW +: DW], m_reg[i][s]);
                    bad = 1;
                end
            end
            n_checks++;
            if (bad) n_fail++;
        end
        bad = 0;
        for (int i = 0; i < NPE; i++) begin
            if (!bad && mask_out[i] !== m_mask[i]) begin
                $display("FAIL %s: element %0d mask actual %0b expected %0b",
                         tag, i, mask_out[i], m_mask[i]);
                bad = 1;
            end
        end
        n_checks++;
        if (bad) n_fail++;
    endtask

    task automatic exec(bit v, int op, int rd, int ra, int rb, int imm,
                        int dir, bit wrap, string tag);
        int  nreg [NPE][NREG];
        bit  nmask[NPE];
        bit  nsave[NPE];
        int  a, b, nb;
        @(negedge clk);
        instr_valid = v;
        instr_op = 4'(op); instr_rd = 2'(rd); instr_ra = 2'(ra); instr_rb = 2'(rb);
        instr_imm = DW'(imm); instr_dir = 2'(dir); instr_wrap = wrap;
        nreg = m_reg; nmask = m_mask; nsave = m_saved;
        if (v) begin
            for (int i = 0; i < NPE; i++) begin
                a = m_reg[i][ra];
                b = m_reg[i][rb];
                case (op)
                    1: if (!m_mask[i]) nreg[i][rd] = (a + b) % 256;
                    2: if (!m_mask[i]) nreg[i][rd] = (a < b) ? 1 : 0;
                    3: begin
                        nsave[i] = m_mask[i];
                        if (!m_mask[i] && !(a < b)) nmask[i] = 1;
                    end
                    4: if (!m_saved[i]) nmask[i] = !m_mask[i];
                    5: nmask[i] = m_saved[i];
                    6: if (!m_mask[i]) begin
                        nb = neighbour(i, dir, wrap);
                        nreg[i][rd] = (nb < 0) ? 0 : m_reg[nb][ra];
                    end
                    7: if (!m_mask[i]) nreg[i][rd] = i;
                    8: if (!m_mask[i]) nreg[i][rd] = imm % 256;
                    default: ;
                endcase
            end
        end
        @(negedge clk);
        instr_valid = 1'b0;
        instr_op = 4'd0;
        m_reg = nreg; m_mask = nmask; m_saved = nsave;
        compare_all(tag);
    endtask

    initial begin
        for (int i = 0; i < NPE; i++) begin
            m_mask[i] = 0; m_saved[i] = 0;
            for (int s = 0; s < NREG; s++) m_reg[i][s] = 0;
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        compare_all("R1 reset state");

        exec(1, 7, 0, 0, 0, 0, 0, 0, "R7 load index");
        exec(1, 8, 1, 0, 0, 8, 0, 0, "R7 load immediate");
        exec(1, 1, 2, 0, 1, 0, 0, 0, "R3 add");
        exec(1, 8, 3, 0, 0, 250, 0, 0, "R7 load immediate 250");
        exec(1, 1, 3, 3, 0, 0, 0, 0, "R3 add wraps modulo");
        exec(1, 2, 3, 0, 1, 0, 0, 0, "R3 compare less-than");
        // if (r0 < r1) then r2 = r0 + r0 else r2 = 0xAA
        exec(1, 3, 0, 0, 1, 0, 0, 0, "R4 set mask on failed condition");
        exec(1, 1, 2, 0, 0, 0, 0, 0, "R2 THEN part on active subset");
        exec(1, 4, 0, 0, 0, 0, 0, 0, "R5 invert mask");
        exec(1, 8, 2, 0, 0, 170, 0, 0, "R2 ELSE part on complement");
        exec(1, 5, 0, 0, 0, 0, 0, 0, "R6 restore mask");
        // neighbour shifts, all elements active
        exec(1, 6, 3, 0, 0, 0, 0, 0, "R8 shift from row-1 no wrap");
        exec(1, 6, 3, 0, 0, 0, 1, 0, "R8 shift from row+1 no wrap");
        exec(1, 6, 3, 0, 0, 0, 2, 1, "R8 shift from col+1 wrap");
        exec(1, 6, 3, 0, 0, 0, 3, 1, "R8 shift from col-1 wrap");
        exec(1, 6, 2, 0, 0, 0, 0, 1, "R8 shift from row-1 wrap");
        exec(1, 6, 2, 0, 0, 0, 3, 0, "R8 shift from col-1 no wrap");
        // ignored instructions
        exec(1, 15, 0, 0, 1, 0, 0, 0, "R9 undefined opcode 15");
        exec(1, 9, 1, 0, 0, 0, 0, 0, "R9 undefined opcode 9");
        exec(1, 0, 2, 0, 1, 0, 0, 0, "R9 opcode 0");
        exec(0, 8, 0, 0, 0, 99, 0, 0, "R10 valid low load");
        exec(0, 3, 0, 1, 0, 0, 0, 0, "R10 valid low set mask");
        // nested conditional: outer masks upper half, inner masks the rest
        exec(1, 8, 1, 0, 0, 8, 0, 0, "R7 reload immediate");
        exec(1, 3, 0, 0, 1, 0, 0, 0, "R4 outer condition");
        exec(1, 3, 0, 1, 0, 0, 0, 0, "R4 masked elements stay masked");
        exec(1, 8, 2, 0, 0, 5, 0, 0, "R2 all masked writes nothing");
        exec(1, 4, 0, 0, 0, 0, 0, 0, "R5 invert spares outer-masked elements");
        exec(1, 6, 2, 0, 0, 0, 1, 0, "R2 masked shift skipped for outer-masked");
        exec(1, 5, 0, 0, 0, 0, 0, 0, "R6 restore inner-saved mask");

        finished = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        #(200000 * 10);
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: run did not complete, actual hung expected done");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end
endmodule